// File: doc/BRIEF.md
# Shared External Memory Bus Arbiter

This block lets a processor core reach three external memory spaces (program, data and boot) through one shared external address bus and one shared data bus. Each space has its own request, address and select line. Only one access uses the bus at a time. If more than one space asks in the same cycle, a fixed priority picks the winner: data first, then program, then boot. Each space has its own programmable wait-state count, so slow memories and memory-mapped peripherals can sit on the bus. The core sees a per-port stall line that holds it until its access reaches its final strobe cycle.

An external master can take the bus by raising `bus_req`. The arbiter answers with `bus_grant`, but only after any access in progress has finished. While the bus is granted, the address outputs and the selects are released: the output enable is low, the selects are low and the address reads zero. The `go_mode` input picks what the core does during a grant:
- With `go_mode` low, `core_halt` is asserted and the core stops.
- With `go_mode` high, the core keeps running from internal memory. Any external request it makes is stalled until the grant ends.

The control is a three-state machine:
- **IDLE**: the bus is free.
- **ACCESS**: one space owns the bus, for 1 + N cycles.
- **GRANT**: the bus belongs to the external master.

The transitions are:
- **IDLE→GRANT** when `bus_req` is high. This takes precedence over core requests.
- **IDLE→ACCESS** when any core request is present.
- **ACCESS→IDLE** on the final wait cycle.
- **GRANT→IDLE** when `bus_req` falls.
- Otherwise the machine stays in its current state.

Top module: `ext_bus_arbiter`

## Requirements
- R1: At most one of `sel_pm`, `sel_dm`, `sel_boot` is high in any cycle. While a select is high, `ext_addr` equals the address its request presented when the access started. Otherwise `ext_addr` is zero.
- R2: An access to a space whose wait input is N (0..7) holds that space's select high for exactly 1 + N consecutive cycles.
- R3: A port's stall output is high whenever its request is high, except in the final select cycle of that port's own access, where it is low.
- R4: When requests arrive in the same cycle, the data access is served first, then program, then boot. A losing port stays stalled until its own access reaches its final cycle.
- R5: A request seen while IDLE (with `bus_req` low) starts its select on the next cycle. One IDLE cycle separates consecutive accesses.
- R6: `bus_grant` rises only in the cycle after an IDLE cycle in which `bus_req` was high. It is never high while a select is high, so an access in progress finishes first.
- R7: While `bus_grant` is high, `addr_oe` is low, all selects are low and `ext_addr` is zero. Otherwise `addr_oe` is high.
- R8: With `go_mode` = 0, `core_halt` is high exactly while `bus_grant` is high.
- R9: With `go_mode` = 1, `core_halt` stays low during a grant. A core request made during the grant stays stalled without any select, and is served once `bus_req` falls.
- R10: `bus_grant` falls on the cycle after the first cycle in which `bus_req` is low.
- R11: After reset, all selects, `bus_grant` and `core_halt` are low and `addr_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm_req | input | 1 | Program-space access request, held until its stall drops |
| pm_addr | input | ADDR_W | Program-space address |
| dm_req | input | 1 | Data-space access request |
| dm_addr | input | ADDR_W | Data-space address |
| boot_req | input | 1 | Boot-space access request |
| boot_addr | input | ADDR_W | Boot-space address |
| pm_wait | input | WAIT_W | Wait states for program space |
| dm_wait | input | WAIT_W | Wait states for data space |
| boot_wait | input | WAIT_W | Wait states for boot space |
| go_mode | input | 1 | 1: core keeps running during a grant; 0: core halts |
| bus_req | input | 1 | External master asks for the bus |
| ext_addr | output | ADDR_W | Shared external address |
| addr_oe | output | 1 | Output enable for address and selects |
| sel_pm | output | 1 | Program-space select |
| sel_dm | output | 1 | Data-space select |
| sel_boot | output | 1 | Boot-space select |
| bus_grant | output | 1 | Bus handed to the external master |
| pm_stall | output | 1 | Stall to the program port |
| dm_stall | output | 1 | Stall to the data port |
| boot_stall | output | 1 | Stall to the boot port |
| core_halt | output | 1 | Core halted during a grant |

## Verification
The selects, address, grant and enable come from registered state. They change one cycle after the edge that samples the request or `bus_req`. The stall lines also depend on the present request, so they answer in the same cycle. The bench drives inputs on the falling edge and samples every output one nanosecond later. A cycle-level model built from the requirements advances once per cycle, so each expected value is compared in the cycle it is due. The directed cases count cycles explicitly: 1 + N select cycles, one IDLE cycle before a grant, and a grant that drops one cycle after `bus_req` falls.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GRANT  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        SP_PM   = 2'd0,
        SP_DM   = 2'd1,
        SP_BOOT = 2'd2
    } space_t;
endpackage

// File: rtl/ebus_prio_pick.sv
module ebus_prio_pick
    import ext_bus_pkg::*;
(
    input  logic   pm_req,
    input  logic   dm_req,
    input  logic   boot_req,
    output logic   any_req,
    output space_t pick
);
    // fixed order: data, then program, then boot
    always_comb begin
        any_req = pm_req | dm_req | boot_req;
        if (dm_req)      pick = SP_DM;
        else if (pm_req) pick = SP_PM;
        else             pick = SP_BOOT;
    end
endmodule

// File: rtl/ebus_wait_cnt.sv
module ebus_wait_cnt #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              at_zero
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm_req,
    input  logic [ADDR_W-1:0] pm_addr,
    input  logic              dm_req,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic              boot_req,
    input  logic [ADDR_W-1:0] boot_addr,
    input  logic [WAIT_W-1:0] pm_wait,
    input  logic [WAIT_W-1:0] dm_wait,
    input  logic [WAIT_W-1:0] boot_wait,
    input  logic              go_mode,
    input  logic              bus_req,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              addr_oe,
    output logic              sel_pm,
    output logic              sel_dm,
    output logic              sel_boot,
    output logic              bus_grant,
    output logic              pm_stall,
    output logic              dm_stall,
    output logic              boot_stall,
    output logic              core_halt
);
    arb_state_t        state_q, state_d;
    space_t            space_q, pick;
    logic [ADDR_W-1:0] addr_q, addr_pick;
    logic [WAIT_W-1:0] wait_pick;
    logic              any_req, start, cnt_zero, in_access, final_cyc;

    ebus_prio_pick u_pick (
        .pm_req   (pm_req),
        .dm_req   (dm_req),
        .boot_req (boot_req),
        .any_req  (any_req),
        .pick     (pick)
    );

    always_comb begin
        unique case (pick)
            SP_PM:   begin wait_pick = pm_wait;   addr_pick = pm_addr;   end
            SP_DM:   begin wait_pick = dm_wait;   addr_pick = dm_addr;   end
            SP_BOOT: begin wait_pick = boot_wait; addr_pick = boot_addr; end
            default: begin wait_pick = '0;        addr_pick = '0;        end
        endcase
    end

    ebus_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (wait_pick),
        .run      (in_access),
        .at_zero  (cnt_zero)
    );

    assign in_access = (state_q == ST_ACCESS);
    assign final_cyc = in_access && cnt_zero;

    // next-state selection
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req)      state_d = ST_GRANT;
                else if (any_req) begin
                    state_d = ST_ACCESS;
                    start   = 1'b1;
                end
            end
            ST_ACCESS: if (cnt_zero) state_d = ST_IDLE;
            ST_GRANT:  if (!bus_req) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and latched access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            space_q <= SP_PM;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                space_q <= pick;
                addr_q  <= addr_pick;
            end
        end
    end

    // outputs
    always_comb begin
        sel_pm     = in_access && (space_q == SP_PM);
        sel_dm     = in_access && (space_q == SP_DM);
        sel_boot   = in_access && (space_q == SP_BOOT);
        ext_addr   = in_access ? addr_q : '0;
        bus_grant  = (state_q == ST_GRANT);
        addr_oe    = (state_q != ST_GRANT);
        core_halt  = (state_q == ST_GRANT) && !go_mode;
        pm_stall   = pm_req   && !(final_cyc && space_q == SP_PM);
        dm_stall   = dm_req   && !(final_cyc && space_q == SP_DM);
        boot_stall = boot_req && !(final_cyc && space_q == SP_BOOT);
    end

    // R1
    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_pm, sel_dm, sel_boot}));
    // R2: select and address held until the final cycle
    a_r2_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && !cnt_zero) |=> ($stable({sel_pm, sel_dm, sel_boot}) && $stable(ext_addr)));
    // R3: final cycle ends the select
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pm && pm_req && !pm_stall) |=> !sel_pm);
    // R6
    a_r6_grant_after_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(!(sel_pm || sel_dm || sel_boot) && bus_req));
    // R7
    a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (!addr_oe && !sel_pm && !sel_dm && !sel_boot && ext_addr == '0));
    // R8
    a_r8_halt_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> (bus_grant && !go_mode));
    // R9
    a_r9_go_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && pm_req) |-> pm_stall);
    // R10
    a_r10_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !bus_req) |=> !bus_grant);
endmodule

// File: tb/ext_bus_arbiter_test.sv
module ext_bus_arbiter_test;
    localparam int AW = 14;
    localparam int WW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req   [3];
    logic [AW-1:0] addr  [3];
    logic [WW-1:0] wt    [3];
    logic          go_mode = 1'b0;
    logic          bus_req = 1'b0;

    logic [AW-1:0] ext_addr;
    logic addr_oe, sel_pm, sel_dm, sel_boot, bus_grant;
    logic pm_stall, dm_stall, boot_stall, core_halt;

    ext_bus_arbiter #(.ADDR_W(AW), .WAIT_W(WW)) uut (
        .clk(clk), .rst_n(rst_n),
        .pm_req(req[0]), .pm_addr(addr[0]),
        .dm_req(req[1]), .dm_addr(addr[1]),
        .boot_req(req[2]), .boot_addr(addr[2]),
        .pm_wait(wt[0]), .dm_wait(wt[1]), .boot_wait(wt[2]),
        .go_mode(go_mode), .bus_req(bus_req),
        .ext_addr(ext_addr), .addr_oe(addr_oe),
        .sel_pm(sel_pm), .sel_dm(sel_dm), .sel_boot(sel_boot),
        .bus_grant(bus_grant),
        .pm_stall(pm_stall), .dm_stall(dm_stall), .boot_stall(boot_stall),
        .core_halt(core_halt)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state: 0 idle, 1 access, 2 grant; index 0 pm, 1 dm, 2 boot
    int            m_st = 0;
    int            m_sp = 0;
    logic [AW-1:0] m_addr = '0;
    int            m_cnt = 0;
    bit            done [3];
    int            sel_cycles [3];
    int            first_sel = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit dsel(input int i);
        case (i)
            0: return sel_pm;
            1: return sel_dm;
            default: return sel_boot;
        endcase
    endfunction

    function automatic bit dstall(input int i);
        case (i)
            0: return pm_stall;
            1: return dm_stall;
            default: return boot_stall;
        endcase
    endfunction

    // compare at +1 ns after a falling edge, advance model, move to next falling edge
    task automatic tick();
        bit acc, es;
        #1;
        acc = (m_st == 1);
        for (int i = 0; i < 3; i++) begin
            chk(dsel(i) == (acc && m_sp == i), "R1 select", dsel(i), acc && m_sp == i);
            es = req[i] && !(acc && m_sp == i && m_cnt == 0);
            chk(dstall(i) == es, "R3 stall", dstall(i), es);
            done[i] = req[i] && !es;
            if (dsel(i)) begin
                sel_cycles[i]++;
                if (first_sel < 0) first_sel = i;
            end
        end
        chk(ext_addr == (acc ? m_addr : '0), "R1 address", ext_addr, acc ? m_addr : 0);
        chk(bus_grant == (m_st == 2), "R6 grant", bus_grant, m_st == 2);
        chk(addr_oe == (m_st != 2), "R7 enable", addr_oe, m_st != 2);
        chk(core_halt == (m_st == 2 && !go_mode), "R8 halt", core_halt, m_st == 2 && !go_mode);
        case (m_st)
            0: begin
                if (bus_req) m_st = 2;
                else if (req[1] || req[0] || req[2]) begin
                    m_sp   = req[1] ? 1 : (req[0] ? 0 : 2);
                    m_st   = 1;
                    m_addr = addr[m_sp];
                    m_cnt  = wt[m_sp];
                end
            end
            1: if (m_cnt == 0) m_st = 0; else m_cnt--;
            default: if (!bus_req) m_st = 0;
        endcase
        @(negedge clk);
        for (int i = 0; i < 3; i++) if (done[i]) req[i] = 1'b0;
    endtask

    task automatic settle();
        bus_req = 1'b0;
        for (int i = 0; i < 3; i++) req[i] = 1'b0;
        repeat (12) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin
            req[i] = 1'b0; addr[i] = '0; wt[i] = '0; done[i] = 0; sel_cycles[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(!sel_pm && !sel_dm && !sel_boot, "R11 selects", {sel_boot, sel_dm, sel_pm}, 0);
        chk(!bus_grant && !core_halt, "R11 grant/halt", {bus_grant, core_halt}, 0);
        chk(addr_oe, "R11 enable", addr_oe, 1);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R5: latency from idle
        req[2] = 1'b1; addr[2] = 14'h155; wt[2] = 3'd0;
        #1;
        chk(!sel_boot && boot_stall, "R5 idle cycle", {sel_boot, boot_stall}, 1);
        tick();
        #1;
        chk(sel_boot && !boot_stall && ext_addr == 14'h155, "R5 select next", {sel_boot, boot_stall}, 2);
        tick();
        settle();

        // R4 / R2: simultaneous program and data
        for (int i = 0; i < 3; i++) sel_cycles[i] = 0;
        first_sel = -1;
        wt[0] = 3'd2; wt[1] = 3'd3;
        addr[0] = 14'h0a0; addr[1] = 14'h3c3;
        req[0] = 1'b1; req[1] = 1'b1;
        repeat (12) tick();
        chk(first_sel == 1, "R4 data first", first_sel, 1);
        chk(sel_cycles[1] == 4, "R2 data strobe length", sel_cycles[1], 4);
        chk(sel_cycles[0] == 3, "R2 program strobe length", sel_cycles[0], 3);
        chk(req[0] == 1'b0, "R4 program served", req[0], 0);
        settle();

        // R6 / R8 / R10: grant waits for access, halt mode
        go_mode = 1'b0;
        wt[1] = 3'd5; addr[1] = 14'h2aa; req[1] = 1'b1;
        tick();
        bus_req = 1'b1;
        k = 0;
        #1;
        while (!bus_grant && k < 20) begin
            chk(!bus_grant, "R6 no early grant", bus_grant, 0);
            tick(); k++;
            #1;
        end
        chk(k == 7, "R6 grant delay", k, 7);
        chk(core_halt, "R8 halt in grant", core_halt, 1);
        tick();
        bus_req = 1'b0;
        #1;
        chk(bus_grant, "R10 grant still held", bus_grant, 1);
        tick();
        #1;
        chk(!bus_grant, "R10 grant dropped", bus_grant, 0);
        settle();

        // R9: GO mode
        go_mode = 1'b1; bus_req = 1'b1;
        tick();
        req[0] = 1'b1; addr[0] = 14'h077; wt[0] = 3'd1;
        for (int j = 0; j < 5; j++) begin
            #1;
            chk(pm_stall && !core_halt && !sel_pm && bus_grant, "R9 stalled in grant",
                {pm_stall, core_halt, sel_pm, bus_grant}, 9);
            tick();
        end
        bus_req = 1'b0;
        tick();
        tick();
        #1;
        chk(sel_pm && ext_addr == 14'h077, "R9 served after release", sel_pm, 1);
        settle();

        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                for (int i = 0; i < 3; i++) wt[i] = WW'($urandom_range(7));
                go_mode = ($urandom_range(1) == 1);
            end
            for (int i = 0; i < 3; i++)
                if (!req[i] && $urandom_range(99) < 20) begin
                    req[i] = 1'b1;
                    addr[i] = AW'($urandom);
                end
            if ($urandom_range(99) < 4) bus_req = !bus_req;
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule